// File: doc/BRIEF.md
# Strobed Output Delay and Pulse Generator

This block sits behind an amplitude analyzer and turns its one-cycle accept pulse into timed output pulses. Each accepted event captures three settings: where the strobe comes from, a range bit and a delay setting. With the internal strobe, the block counts a programmable delay and then fires. With the external strobe, it opens an acceptance window. It fires on the first synchronized rising edge of the strobe line. If the window runs out with no edge, it returns to idle without any output.

The two outputs are a fast pulse, two cycles wide, and a slow pulse, fifty cycles wide, and both start in the same cycle. A busy flag is high from the cycle after an accept until a recovery tail after the pulse ends. While busy is high, further accept pulses are dropped. All timings are given for a 10 ns clock period, and every length is a parameter written in nanoseconds.

Top module: `strobed_pulse_gen`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `fast_o`, `slow_o` and `busy_o` are all low.
- R2: With `ext_sel_i`=0 and `long_range_i`=0, the outputs rise N clock edges after the edge that took the accept, where N = ceil((100 + S)/10) and S is the delay setting (N runs from 10 to 110).
- R3: With `ext_sel_i`=0 and `long_range_i`=1, N = 100 + S (N runs from 100 to 1100).
- R4: A delay setting above 1000 acts exactly as 1000.
- R5: Strobe source, range and setting are captured on the accept edge. Changing them later does not affect the event in progress.
- R6: With `ext_sel_i`=1, a rising edge of `strobe_i` makes the outputs rise on the second clock edge after the first edge that samples the strobe high, provided that the edge falls inside the window.
- R7: The external window spans edges 1 to W after the accept edge, with W = 500 when `long_range_i`=0 and W = 5000 when it is 1. When the window expires with no edge, busy drops after edge W and no pulse appears.
- R8: Strobe edges seen while idle have no effect. A strobe that was already high before the accept and stays high does not fire.
- R9: `slow_o` stays high for 50 cycles and `fast_o` for 2 cycles, and both rise in the same cycle.
- R10: `busy_o` rises on the edge after an idle accept and stays high through the wait and for 70 cycles from the start of the pulse. Accept pulses that arrive while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, 10 ns nominal |
| rst_i | input | 1 | Synchronous reset, active high |
| accept_i | input | 1 | One-cycle event accept from the analyzer |
| ext_sel_i | input | 1 | 1 = external strobe, 0 = internal delay |
| long_range_i | input | 1 | 1 = long delay span and 50 µs window, 0 = short |
| delay_set_i | input | 10 | Delay setting, 0 to 1000 used |
| strobe_i | input | 1 | Asynchronous external strobe line |
| fast_o | output | 1 | Short output pulse |
| slow_o | output | 1 | Wide output pulse |
| busy_o | output | 1 | Event in progress; new accepts blocked |

## Verification
Every output is registered, so a result never shows in the cycle of its stimulus. An internal event fires N edges after the accept edge. An external event fires two edges after the first edge that samples the strobe high. An expiring window clears busy W edges after the accept. A behavioural model counts these same latencies in integers on each rising edge. The bench compares all three outputs with the model on every falling edge. Directed tests also count falling edges from accept to pulse, so the latency shows up as N+1 (or 3 for the strobe).

// File: rtl/spg_pkg.sv
package spg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DELAY  = 2'd1,
        ST_WINDOW = 2'd2,
        ST_PULSE  = 2'd3
    } spg_state_e;
endpackage

// File: rtl/spg_strobe_edge.sv
module spg_strobe_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic strobe_i,
    output logic rise_o
);
    logic [STAGES:0] shift_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) shift_q <= '0;
        else       shift_q <= {shift_q[STAGES-1:0], strobe_i};
    end

    assign rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/spg_target.sv
module spg_target #(
    parameter int EL_W        = 17,
    parameter int SET_W       = 10,
    parameter int SET_MAX     = 1000,
    parameter int LO_BASE_NS  = 100,
    parameter int HI_BASE_NS  = 1000,
    parameter int LO_STEP_NS  = 1,
    parameter int HI_STEP_NS  = 10,
    parameter int LO_WIN_NS   = 5000,
    parameter int HI_WIN_NS   = 50000
) (
    input  logic             ext_sel_i,
    input  logic             long_range_i,
    input  logic [SET_W-1:0] setting_i,
    output logic [EL_W-1:0]  target_o
);
    logic [EL_W-1:0] set_clamped;

    always_comb begin
        if (int'(setting_i) > SET_MAX) set_clamped = EL_W'(SET_MAX);
        else                           set_clamped = EL_W'(setting_i);

        if (ext_sel_i)
            target_o = long_range_i ? EL_W'(HI_WIN_NS) : EL_W'(LO_WIN_NS);
        else if (long_range_i)
            target_o = EL_W'(HI_BASE_NS) + set_clamped * EL_W'(HI_STEP_NS);
        else
            target_o = EL_W'(LO_BASE_NS) + set_clamped * EL_W'(LO_STEP_NS);
    end
endmodule

// File: rtl/strobed_pulse_gen.sv
module strobed_pulse_gen #(
    parameter int CLK_NS      = 10,
    parameter int SET_W       = 10,
    parameter int SET_MAX     = 1000,
    parameter int LO_BASE_NS  = 100,
    parameter int HI_BASE_NS  = 1000,
    parameter int LO_STEP_NS  = 1,
    parameter int HI_STEP_NS  = 10,
    parameter int LO_WIN_NS   = 5000,
    parameter int HI_WIN_NS   = 50000,
    parameter int SLOW_NS     = 500,
    parameter int FAST_NS     = 20,
    parameter int SLOW_TAIL_NS = 200,
    parameter int FAST_TAIL_NS = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             accept_i,
    input  logic             ext_sel_i,
    input  logic             long_range_i,
    input  logic [SET_W-1:0] delay_set_i,
    input  logic             strobe_i,
    output logic             fast_o,
    output logic             slow_o,
    output logic             busy_o
);
    import spg_pkg::*;

    localparam int MAX_DELAY_NS = HI_BASE_NS + SET_MAX * HI_STEP_NS;
    localparam int MAX_NS   = (MAX_DELAY_NS > HI_WIN_NS ? MAX_DELAY_NS : HI_WIN_NS) + CLK_NS;
    localparam int EL_W     = $clog2(MAX_NS + 1);
    localparam int SLOW_CYC = SLOW_NS / CLK_NS;
    localparam int FAST_CYC = FAST_NS / CLK_NS;
    localparam int HOLD_SLOW = (SLOW_NS + SLOW_TAIL_NS) / CLK_NS;
    localparam int HOLD_FAST = (FAST_NS + FAST_TAIL_NS) / CLK_NS;
    localparam int HOLD_CYC = HOLD_SLOW > HOLD_FAST ? HOLD_SLOW : HOLD_FAST;
    localparam int PC_W     = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        spg_state_e      st;
        logic [EL_W-1:0] elapsed;
        logic [EL_W-1:0] target;
        logic [PC_W-1:0] pcount;
    } spg_regs_t;

    spg_regs_t r_q, r_d;
    logic            strobe_rise;
    logic [EL_W-1:0] new_target;

    spg_strobe_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .strobe_i (strobe_i),
        .rise_o   (strobe_rise)
    );

    spg_target #(
        .EL_W(EL_W), .SET_W(SET_W), .SET_MAX(SET_MAX),
        .LO_BASE_NS(LO_BASE_NS), .HI_BASE_NS(HI_BASE_NS),
        .LO_STEP_NS(LO_STEP_NS), .HI_STEP_NS(HI_STEP_NS),
        .LO_WIN_NS(LO_WIN_NS), .HI_WIN_NS(HI_WIN_NS)
    ) u_target (
        .ext_sel_i    (ext_sel_i),
        .long_range_i (long_range_i),
        .setting_i    (delay_set_i),
        .target_o     (new_target)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept_i) begin
                    r_d.st      = ext_sel_i ? ST_WINDOW : ST_DELAY;
                    r_d.elapsed = EL_W'(CLK_NS);
                    r_d.target  = new_target;
                    r_d.pcount  = '0;
                end
            end
            ST_DELAY: begin
                if (r_q.elapsed >= r_q.target) begin
                    r_d.st     = ST_PULSE;
                    r_d.pcount = '0;
                end else begin
                    r_d.elapsed = r_q.elapsed + EL_W'(CLK_NS);
                end
            end
            ST_WINDOW: begin
                if (strobe_rise) begin
                    r_d.st     = ST_PULSE;
                    r_d.pcount = '0;
                end else if (r_q.elapsed >= r_q.target) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.elapsed = r_q.elapsed + EL_W'(CLK_NS);
                end
            end
            ST_PULSE: begin
                if (r_q.pcount == PC_W'(HOLD_CYC - 1)) r_d.st = ST_IDLE;
                else r_d.pcount = r_q.pcount + 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q.st      <= ST_IDLE;
            r_q.elapsed <= '0;
            r_q.target  <= '0;
            r_q.pcount  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.st != ST_IDLE);
    assign slow_o = (r_q.st == ST_PULSE) && (r_q.pcount < PC_W'(SLOW_CYC));
    assign fast_o = (r_q.st == ST_PULSE) && (r_q.pcount < PC_W'(FAST_CYC));
endmodule

// File: rtl/spg_checker.sv
module spg_checker (
    input logic clk_i,
    input logic rst_i,
    input logic accept_i,
    input logic fast_o,
    input logic slow_o,
    input logic busy_o
);
    assert_fast_within_slow_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        fast_o |-> slow_o);
    assert_common_start_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(slow_o) |-> fast_o);
    assert_pulse_needs_event_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(slow_o) |-> $past(busy_o));
    assert_busy_from_accept_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(busy_o) |-> $past(accept_i));
    assert_quiet_at_release_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |-> (!slow_o && !fast_o));
    assert_slow_inside_busy_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        slow_o |-> busy_o);
endmodule

bind strobed_pulse_gen spg_checker u_spg_checker (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .accept_i (accept_i),
    .fast_o   (fast_o),
    .slow_o   (slow_o),
    .busy_o   (busy_o)
);

// File: tb/test_strobed_pulse_gen.sv
module test_strobed_pulse_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       accept = 1'b0;
    logic       ext_sel = 1'b0;
    logic       long_range = 1'b0;
    logic [9:0] dset = '0;
    logic       strobe = 1'b0;
    logic       fast, slow, busy;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    strobed_pulse_gen i_strobed_pulse_gen (
        .clk_i(clk), .rst_i(rst), .accept_i(accept), .ext_sel_i(ext_sel),
        .long_range_i(long_range), .delay_set_i(dset), .strobe_i(strobe),
        .fast_o(fast), .slow_o(slow), .busy_o(busy)
    );

    // behavioural reference model
    int m_st = 0, m_cnt = 0, m_age = 0;
    bit h0 = 0, h1 = 0, h2 = 0;

    function automatic int delay_cycles(bit rng, int s);
        int sc = (s > 1000) ? 1000 : s;
        return rng ? (100 + sc) : ((100 + sc + 9) / 10);
    endfunction

    always @(posedge clk) begin
        bit rise;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_age = 0; h0 = 0; h1 = 0; h2 = 0;
        end else begin
            rise = h1 && !h2;
            h2 = h1; h1 = h0; h0 = strobe;
            case (m_st)
                0: if (accept) begin
                       if (ext_sel) begin m_st = 2; m_cnt = long_range ? 5000 : 500; end
                       else begin m_st = 1; m_cnt = delay_cycles(long_range, int'(dset)); end
                   end
                1: begin m_cnt--; if (m_cnt == 0) begin m_st = 3; m_age = 0; end end
                2: if (rise) begin m_st = 3; m_age = 0; end
                   else begin m_cnt--; if (m_cnt == 0) m_st = 0; end
                default: begin m_age++; if (m_age == 70) m_st = 0; end
            endcase
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(cur_req, "busy", int'(busy), int'(m_st != 0));
            check(cur_req, "slow", int'(slow), int'(m_st == 3 && m_age < 50));
            check(cur_req, "fast", int'(fast), int'(m_st == 3 && m_age < 2));
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic wait_idle();
        for (int i = 0; i < 7000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        repeat (3) @(negedge clk);
    endtask

    // returns falling edges from accept drive until slow is seen (0 if none within lim)
    task automatic fire(bit ext, bit rng, int s, int lim, output int cnt);
        @(negedge clk);
        ext_sel = ext; long_range = rng; dset = 10'(s); accept = 1'b1;
        cnt = 0;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            accept = 1'b0;
            if (slow) begin cnt = i; break; end
        end
        accept = 1'b0;
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        check("R1", "reset slow", int'(slow), 0);
        check("R1", "reset busy", int'(busy), 0);
        check("R1", "reset fast", int'(fast), 0);
        rst = 1'b0;

        cur_req = "R2";
        fire(0, 0, 0, 200, c);    check("R2", "lat s0", c, 11);    wait_idle();
        fire(0, 0, 555, 200, c);  check("R2", "lat s555", c, 67);  wait_idle();
        fire(0, 0, 1000, 200, c); check("R2", "lat s1000", c, 111); wait_idle();
        cur_req = "R3";
        fire(0, 1, 0, 2000, c);    check("R3", "lat s0", c, 101);   wait_idle();
        fire(0, 1, 1000, 2000, c); check("R3", "lat s1000", c, 1101); wait_idle();
        cur_req = "R4";
        fire(0, 0, 1023, 200, c);  check("R4", "lat clamp lo", c, 111); wait_idle();
        fire(0, 1, 1010, 2000, c); check("R4", "lat clamp hi", c, 1101); wait_idle();

        cur_req = "R5";
        @(negedge clk); ext_sel = 0; long_range = 0; dset = 10'd5; accept = 1;
        @(negedge clk); accept = 0; long_range = 1; dset = 10'd1000; ext_sel = 1;
        c = 1;
        for (int i = 2; i < 50; i++) begin @(negedge clk); if (slow) begin c = i; break; end end
        check("R5", "lat captured", c, 12);
        wait_idle();

        cur_req = "R9";
        fire(0, 0, 40, 200, c);
        check("R9", "fast at start", int'(fast), 1);
        repeat (2) @(negedge clk);
        check("R9", "fast ended", int'(fast), 0);
        repeat (47) @(negedge clk);
        check("R9", "slow last", int'(slow), 1);
        @(negedge clk);
        check("R9", "slow ended", int'(slow), 0);
        wait_idle();

        cur_req = "R10";
        @(negedge clk); ext_sel = 0; long_range = 0; dset = 10'd300; accept = 1;
        @(negedge clk); accept = 0;
        repeat (10) @(negedge clk);
        dset = 10'd0; accept = 1;
        @(negedge clk); accept = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (slow) begin
                accept = 1; @(negedge clk); accept = 0;
                break;
            end
        end
        wait_idle();
        check("R10", "idle after ignored accepts", int'(busy), 0);

        cur_req = "R8";
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); strobe = 1; repeat (4) @(negedge clk); strobe = 0;
        end
        repeat (5) @(negedge clk);
        check("R8", "idle strobe", int'(busy), 0);

        cur_req = "R6";
        fire(1, 0, 0, 100, c);
        strobe = 1; c = 0;
        for (int i = 1; i < 10; i++) begin @(negedge clk); if (slow) begin c = i; break; end end
        check("R6", "strobe latency", c, 3);
        strobe = 0;
        wait_idle();

        cur_req = "R7";
        fire(1, 0, 0, 600, c);
        check("R7", "no pulse lo window", c, 0);
        wait_idle();
        fire(1, 1, 0, 4000, c);
        strobe = 1; repeat (5) @(negedge clk); strobe = 0;
        wait_idle();
        fire(1, 1, 0, 5200, c);
        check("R7", "no pulse hi window", c, 0);
        check("R7", "busy cleared", int'(busy), 0);

        cur_req = "R8";
        @(negedge clk); strobe = 1;
        repeat (4) @(negedge clk);
        fire(1, 0, 0, 300, c);
        check("R8", "held strobe no fire", c, 0);
        strobe = 0;
        wait_idle();

        cur_req = "R7";
        fire(1, 0, 0, 496, c);
        strobe = 1; repeat (4) @(negedge clk); strobe = 0;
        wait_idle();
        fire(1, 0, 0, 499, c);
        strobe = 1; repeat (4) @(negedge clk); strobe = 0;
        wait_idle();

        finish_run();
    end
endmodule